// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block sits next to the program counter of a processor and runs hardware loops without a branch instruction in the loop body. Software loads a first-word address, a last-word address and an iteration count through a setup strobe. After that, every time an instruction word completes, the block checks whether the PC the word produced equals the last-word address. On a match it uses up one iteration and sends the PC back to the first word. When the final iteration is used up it drops out of loop mode and lets execution continue past the body.

The block also supplies the default sequential step. If the address chosen after the loop check is still the address the completed word was fetched from, the next PC is that address plus one. Addresses count 32-bit words, so one unit is one instruction word. A flush input, driven by exception handling, ends loop mode at once. The loop registers and the active flag are brought out for debug.

Top module: `rpt_loop_ctrl`

## Requirements
- R1: After synchronous active-low reset, the active flag, the count, the start address and the end address all read zero.
- R2: A setup strobe loads start, end and count from the setup inputs in one cycle, and sets the active flag when the loaded count is nonzero.
- R3: A setup strobe with a count of zero loads the registers but leaves the active flag clear, so no loop-back happens afterwards.
- R4: A loop match needs all of the following: the active flag set, the word-complete strobe high, flush low, and the post-word PC equal to the end address. Without a match, the count and the active flag keep their values and the next PC is built from the post-word PC alone.
- R5: On a match, the count drops by exactly one in the following cycle. While the active flag is set, the count is never zero.
- R6: On a match where the decremented count is nonzero, the candidate next PC is the start address.
- R7: On a match where the decremented count is zero, the active flag clears and the candidate next PC is the post-word PC. A loop of count N with a body of two or more words therefore runs exactly N passes.
- R8: After the loop decision, if the candidate equals the pre-word PC, the next PC is the candidate plus one, wrapping modulo 2^ADDR_W. Otherwise the next PC is the candidate. As a result, a one-word body (start equals end) steps past itself after one pass and keeps the active flag set with its count reduced.
- R9: Flush clears the active flag in the next cycle and blocks a loop-back in its own cycle. Flush also wins over a simultaneous setup strobe, whose registers still load.
- R10: The debug outputs always show the current start, end, count and active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Exception flush; ends loop mode |
| cfg_load_i | input | 1 | Setup strobe |
| cfg_start_i | input | ADDR_W | First word of the loop body |
| cfg_end_i | input | ADDR_W | Last word of the loop body |
| cfg_count_i | input | CNT_W | Number of passes |
| word_done_i | input | 1 | An instruction word completed this cycle |
| pc_before_i | input | ADDR_W | PC the completed word was fetched from |
| pc_after_i | input | ADDR_W | PC left by executing the word |
| next_pc_o | output | ADDR_W | PC for the next fetch (combinational) |
| loop_active_o | output | 1 | Loop mode active |
| dbg_start_o | output | ADDR_W | Current start address |
| dbg_end_o | output | ADDR_W | Current end address |
| dbg_count_o | output | CNT_W | Remaining passes |

## Verification
The main function is exercised by sweeping the pass count from zero to five against body lengths of one to four words, walking the PC sequentially through each body. The number of words executed before the PC leaves the body separates correct decrement-and-expire behaviour from an off-by-one in the expiry test. The one-word body isolates the pre-word comparison that decides between looping and stepping. Jumps that land on or away from the end address show that the match uses the post-word PC. Flush alone, flush combined with setup, and a PC wrap at the top of the address space cover the remaining priority and arithmetic corners.

// File: rtl/rpt_pkg.sv
// Package: shared types and defaults for the repeat loop controller.
// Assumes: word addressing, one unit per instruction word.
package rpt_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int CNT_W_DEF  = 16;

    // Source of the candidate next PC before the sequential step.
    typedef enum logic [0:0] {
        PCSRC_EXEC = 1'b0,
        PCSRC_LOOP = 1'b1
    } pc_src_e;
endpackage

// File: rtl/rpt_state.sv
// Module: holds start, end, remaining count and active flag.
// Assumes: load has priority over decrement, flush over everything for the flag.
module rpt_state #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_start_i,
    input  logic [ADDR_W-1:0] load_end_i,
    input  logic [CNT_W-1:0]  load_count_i,
    input  logic              dec_i,
    input  logic              expire_i,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              active_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Address and count registers: setup load or per-match decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            count_q <= '0;
        end else if (load_i) begin
            start_q <= load_start_i;
            end_q   <= load_end_i;
            count_q <= load_count_i;
        end else if (dec_i) begin
            count_q <= count_q - ONE;
        end
    end

    // Active flag: flush clears, setup arms on nonzero count, expiry clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (flush_i) begin
            active_q <= 1'b0;
        end else if (load_i) begin
            active_q <= |load_count_i;
        end else if (expire_i) begin
            active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rpt_match.sv
// Module: decides whether the completed word closes a loop pass.
// Assumes: count is nonzero whenever active is set.
module rpt_match #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              active_i,
    input  logic              word_done_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] pc_after_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              hit_o,
    output logic              expire_o,
    output logic              take_loop_o
);
    logic [CNT_W-1:0] count_dec;

    // Match on end address, then split into loop-back or expiry.
    always_comb begin
        count_dec   = count_i - CNT_W'(1);
        hit_o       = active_i && word_done_i && !flush_i && (pc_after_i == end_i);
        expire_o    = hit_o && (count_dec == '0);
        take_loop_o = hit_o && (count_dec != '0);
    end
endmodule

// File: rtl/rpt_pc_sel.sv
// Module: builds the next PC from the loop decision and the sequential rule.
// Assumes: an unchanged PC means the word did not redirect and must advance.
module rpt_pc_sel #(
    parameter int ADDR_W = 16
) (
    input  logic              take_loop_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] pc_before_i,
    input  logic [ADDR_W-1:0] pc_after_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    import rpt_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    pc_src_e           src;
    logic [ADDR_W-1:0] cand;

    // Pick the candidate, then step it if it did not move.
    always_comb begin
        src       = take_loop_i ? PCSRC_LOOP : PCSRC_EXEC;
        cand      = (src == PCSRC_LOOP) ? start_i : pc_after_i;
        next_pc_o = (cand == pc_before_i) ? (cand + STEP) : cand;
    end
endmodule

// File: rtl/rpt_loop_ctrl.sv
// Module: top of the zero-overhead repeat loop controller.
// Assumes: one completed word per strobe; next_pc_o is combinational.
module rpt_loop_ctrl #(
    parameter int ADDR_W = rpt_pkg::ADDR_W_DEF,
    parameter int CNT_W  = rpt_pkg::CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              cfg_load_i,
    input  logic [ADDR_W-1:0] cfg_start_i,
    input  logic [ADDR_W-1:0] cfg_end_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic              word_done_i,
    input  logic [ADDR_W-1:0] pc_before_i,
    input  logic [ADDR_W-1:0] pc_after_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              loop_active_o,
    output logic [ADDR_W-1:0] dbg_start_o,
    output logic [ADDR_W-1:0] dbg_end_o,
    output logic [CNT_W-1:0]  dbg_count_o
);
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [CNT_W-1:0]  count_q;
    logic              active_q;
    logic              hit;
    logic              expire;
    logic              take_loop;

    rpt_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .load_i       (cfg_load_i),
        .load_start_i (cfg_start_i),
        .load_end_i   (cfg_end_i),
        .load_count_i (cfg_count_i),
        .dec_i        (hit),
        .expire_i     (expire),
        .start_q      (start_q),
        .end_q        (end_q),
        .count_q      (count_q),
        .active_q     (active_q)
    );

    rpt_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .active_i    (active_q),
        .word_done_i (word_done_i),
        .flush_i     (flush_i),
        .pc_after_i  (pc_after_i),
        .end_i       (end_q),
        .count_i     (count_q),
        .hit_o       (hit),
        .expire_o    (expire),
        .take_loop_o (take_loop)
    );

    rpt_pc_sel #(.ADDR_W(ADDR_W)) u_pc_sel (
        .take_loop_i (take_loop),
        .start_i     (start_q),
        .pc_before_i (pc_before_i),
        .pc_after_i  (pc_after_i),
        .next_pc_o   (next_pc_o)
    );

    // Debug view of the loop registers.
    always_comb begin
        loop_active_o = active_q;
        dbg_start_o   = start_q;
        dbg_end_o     = end_q;
        dbg_count_o   = count_q;
    end
endmodule

// File: rtl/rpt_loop_ctrl_chk.sv
// Module: property checker for rpt_loop_ctrl, attached by bind.
// Assumes: observes top-level ports only.
module rpt_loop_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              cfg_load_i,
    input logic [ADDR_W-1:0] cfg_start_i,
    input logic [CNT_W-1:0]  cfg_count_i,
    input logic              word_done_i,
    input logic [ADDR_W-1:0] pc_before_i,
    input logic [ADDR_W-1:0] pc_after_i,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              loop_active_o,
    input logic [ADDR_W-1:0] dbg_start_o,
    input logic [ADDR_W-1:0] dbg_end_o,
    input logic [CNT_W-1:0]  dbg_count_o
);
    logic match_now;
    assign match_now = word_done_i && loop_active_o && !flush_i && (pc_after_i == dbg_end_o);

    assert_start_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |=> dbg_start_o == $past(cfg_start_i));

    assert_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_i && cfg_count_i == '0) |=> !loop_active_o);

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_done_i && !cfg_load_i && !flush_i) |=> ($stable(dbg_count_o) && $stable(loop_active_o)));

    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_now && !cfg_load_i) |=> dbg_count_o == $past(dbg_count_o) - CNT_W'(1));

    assert_active_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active_o |-> dbg_count_o != '0);

    assert_loopback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_now && dbg_count_o > CNT_W'(1) && dbg_start_o != pc_before_i) |-> next_pc_o == dbg_start_o);

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_now && pc_after_i == pc_before_i) |-> next_pc_o == pc_before_i + ADDR_W'(1));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !loop_active_o);
endmodule

bind rpt_loop_ctrl rpt_loop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .cfg_load_i    (cfg_load_i),
    .cfg_start_i   (cfg_start_i),
    .cfg_count_i   (cfg_count_i),
    .word_done_i   (word_done_i),
    .pc_before_i   (pc_before_i),
    .pc_after_i    (pc_after_i),
    .next_pc_o     (next_pc_o),
    .loop_active_o (loop_active_o),
    .dbg_start_o   (dbg_start_o),
    .dbg_end_o     (dbg_end_o),
    .dbg_count_o   (dbg_count_o)
);

// File: tb/test_rpt_loop_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps pass count and body length; bench model follows the requirements.
module test_rpt_loop_ctrl;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          cfg_load_i = 1'b0;
    logic [AW-1:0] cfg_start_i = '0;
    logic [AW-1:0] cfg_end_i = '0;
    logic [CW-1:0] cfg_count_i = '0;
    logic          word_done_i = 1'b0;
    logic [AW-1:0] pc_before_i = '0;
    logic [AW-1:0] pc_after_i = '0;
    logic [AW-1:0] next_pc_o;
    logic          loop_active_o;
    logic [AW-1:0] dbg_start_o;
    logic [AW-1:0] dbg_end_o;
    logic [CW-1:0] dbg_count_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [AW-1:0] m_start = '0;
    logic [AW-1:0] m_end = '0;
    logic [CW-1:0] m_count = '0;
    logic          m_active = 1'b0;

    always #2.5 clk = ~clk;

    rpt_loop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_rpt_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .cfg_load_i(cfg_load_i),
        .cfg_start_i(cfg_start_i), .cfg_end_i(cfg_end_i), .cfg_count_i(cfg_count_i),
        .word_done_i(word_done_i), .pc_before_i(pc_before_i), .pc_after_i(pc_after_i),
        .next_pc_o(next_pc_o), .loop_active_o(loop_active_o), .dbg_start_o(dbg_start_o),
        .dbg_end_o(dbg_end_o), .dbg_count_o(dbg_count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(loop_active_o == m_active, {req, " active"}, int'(loop_active_o), int'(m_active));
        chk(dbg_count_o == m_count, {req, " count"}, int'(dbg_count_o), int'(m_count));
        chk(dbg_start_o == m_start, {req, " start"}, int'(dbg_start_o), int'(m_start));
        chk(dbg_end_o == m_end, {req, " end"}, int'(dbg_end_o), int'(m_end));
    endtask

    // Setup strobe, optionally with flush (R2, R3, R9, R10).
    task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] e,
                           input logic [CW-1:0] n, input bit fl, input string req);
        cfg_load_i = 1'b1; cfg_start_i = s; cfg_end_i = e; cfg_count_i = n; flush_i = fl;
        @(posedge clk);
        m_start = s; m_end = e; m_count = n;
        m_active = fl ? 1'b0 : (n != '0);
        @(negedge clk);
        cfg_load_i = 1'b0; flush_i = 1'b0;
        #1;
        check_regs(req);
    endtask

    // One completed word; returns the expected next PC.
    task automatic do_word(input logic [AW-1:0] pcb, input logic [AW-1:0] pca,
                           input bit fl, input string req, output logic [AW-1:0] npc);
        logic          hit;
        logic [CW-1:0] dec;
        logic [AW-1:0] cand;
        word_done_i = 1'b1; pc_before_i = pcb; pc_after_i = pca; flush_i = fl;
        hit  = m_active && !fl && (pca == m_end);
        dec  = m_count - CW'(1);
        cand = (hit && dec != '0) ? m_start : pca;
        npc  = (cand == pcb) ? cand + AW'(1) : cand;
        #1;
        chk(next_pc_o == npc, {req, " next_pc"}, int'(next_pc_o), int'(npc));
        @(posedge clk);
        if (hit) m_count = dec;
        if (fl || (hit && dec == '0)) m_active = 1'b0;
        @(negedge clk);
        word_done_i = 1'b0; flush_i = 1'b0;
        #1;
        check_regs(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] npc;
        repeat (3) @(negedge clk);
        // R1: reset state and sequential step from zero (R8)
        #1;
        check_regs("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_word(16'h0000, 16'h0000, 1'b0, "R8 step from reset", npc);

        // Sweep: pass count 0..5, body length 1..4 (R2 R3 R5 R6 R7 R8)
        for (int n = 0; n <= 5; n++) begin
            for (int l = 1; l <= 4; l++) begin
                logic [AW-1:0] s;
                logic [AW-1:0] pc;
                int words;
                int exp_words;
                bit exp_act;
                s = AW'(16'h0100 + n * 64 + l * 8);
                do_load(s, s + AW'(l - 1), CW'(n), 1'b0, (n == 0) ? "R3 zero load" : "R2 load");
                pc = s;
                words = 0;
                while (pc >= s && pc < s + AW'(l) && words < 60) begin
                    do_word(pc, pc, 1'b0, "R6 R7 sweep", npc);
                    pc = npc;
                    words++;
                end
                exp_words = (l == 1 || n == 0) ? l : l * n;
                exp_act = (l == 1 && n > 1);
                chk(words == exp_words, "R7 pass count", words, exp_words);
                chk(loop_active_o == exp_act, "R8 one-word body active", int'(loop_active_o), int'(exp_act));
                chk(pc == s + AW'(l), "R7 exit pc", int'(pc), int'(s + AW'(l)));
            end
        end

        // R4: jump landing on end address triggers a match
        do_load(16'h0200, 16'h0207, 16'd3, 1'b0, "R2 load");
        do_word(16'h0300, 16'h0207, 1'b0, "R4 jump to end", npc);
        chk(npc == 16'h0200, "R4 jump loops to start", int'(npc), 16'h0200);
        // R4: jump elsewhere leaves state and passes pc_after through
        do_word(16'h0205, 16'h0400, 1'b0, "R4 jump away", npc);
        chk(npc == 16'h0400, "R4 jump away pc", int'(npc), 16'h0400);
        // R4: end PC without word strobe changes nothing
        pc_after_i = 16'h0207; pc_before_i = 16'h0207;
        @(posedge clk); @(negedge clk); #1;
        check_regs("R4 no strobe");
        // R9: flush on the end word blocks loop-back and clears active
        do_word(16'h0207, 16'h0207, 1'b1, "R9 flush on end", npc);
        chk(npc == 16'h0208, "R9 flush pc", int'(npc), 16'h0208);
        // R9: flush beats a simultaneous setup
        do_load(16'h0500, 16'h0503, 16'd4, 1'b1, "R9 flush with load");
        // R8: wrap at top of address space
        do_word(16'hFFFF, 16'hFFFF, 1'b0, "R8 wrap", npc);
        chk(npc == 16'h0000, "R8 wrap value", int'(npc), 0);
        // R10 / R1: reset mid-loop returns everything to zero
        do_load(16'h0600, 16'h0601, 16'd2, 1'b0, "R10 debug view");
        rst_n = 1'b0;
        @(posedge clk);
        m_start = '0; m_end = '0; m_count = '0; m_active = 1'b0;
        @(negedge clk); #1;
        check_regs("R1 reset mid-loop");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule